// File: doc/BRIEF.md
# Cycle Counter Compare Timer

This block keeps a free-running cycle counter and three compare channels beside it. The counter advances by one on every clock. Each channel holds a compare value. A channel latches a pending flag when the counter reaches that value. The flag stays up until software writes the same channel again, so the write that arms the next deadline also acknowledges the previous one.

Software sees a read path for the counter and a write path for the compare values, with a read-back of the compare values selected by index. The three pending flags sit at fixed positions in a 32-bit interrupt vector, which goes to an interrupt controller that handles masking and priority. Reset is asserted asynchronously and released through a two-stage synchronizer. The counter therefore starts moving two clocks after the reset input goes high.

Top module: `cyc_cmp_timer`

## Requirements
- R1: While reset is asserted, `count_o` reads 0, every compare value reads back as 0 and `irq_o` is all zero.
- R2: Out of reset, `count_o` grows by exactly 1 on every clock, so two reads one cycle apart differ by 1.
- R3: The counter wraps from all ones to 0 and carries on counting.
- R4: Channel 0 drives bit 6 of `irq_o`, channel 1 drives bit 10 and channel 2 drives bit 13. All other bits of `irq_o` are always 0.
- R5: A channel's pending bit is set at the clock edge that ends a cycle in which the counter equals its compare value in all bits. The bit is first seen when `count_o` equals the compare value plus 1. When reset releases, the zero counter matches the zero compare values, so all three bits come up together.
- R6: Once set, a pending bit stays set for as long as its own channel is not written.
- R7: A write to a channel clears its pending bit at the same clock edge that loads the new compare value. The write wins over a match in that cycle. A write whose value equals the count at the write edge is already passed, and it never sets the bit.
- R8: A write to one channel, or a match on one channel, leaves the pending bits and compare values of the other channels unchanged.
- R9: `cmp_rdata_o` returns the compare value of the channel selected by `cmp_rsel_i` (0, 1 or 2), and returns 0 for index 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wsel_i | input | 2 | Channel index for the write |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| cmp_rsel_i | input | 2 | Channel index for read-back |
| cmp_rdata_o | output | CNT_W | Compare value read-back |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | IRQ_W | Interrupt vector holding the pending bits |

## Verification
Each channel is armed at the current count plus 20, by itself, to confirm that the exact rise cycle and the clear on write belong to that one channel. Two channels are then armed 5 and 12 cycles ahead with overlapping windows, so that a shared or cross-wired pending bit would show. Offsets of +1 and +0 exercise a match in the first cycle after the write and a match that has already been passed. A write that lands in the matching cycle itself shows that the clear wins. A narrow counter instance shows the wrap.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned IRQ_POS [NUM_CMP] = '{6, 10, 13};

  function automatic logic [31:0] irq_mask_f();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < int'(NUM_CMP); i++) m[IRQ_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cct_rst_sync.sv
module cct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             pend_q, pend_d;
  logic             hit;

  always_comb begin
    hit    = (count_i == cmp_q);
    cmp_d  = wr_en_i ? wdata_i : cmp_q;
    pend_d = wr_en_i ? 1'b0 : (pend_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_q <= '0;
    else if (wr_en_i) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer
  import cct_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr_i,
  input  logic [SEL_W-1:0] cmp_wsel_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [SEL_W-1:0] cmp_rsel_i,
  output logic [CNT_W-1:0] cmp_rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic [IRQ_W-1:0] irq_o
);
  logic                            rst_sync_n;
  logic [NUM_CMP-1:0]              wr_en;
  logic [NUM_CMP-1:0]              pend;
  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_q;

  cct_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .count_o(count_o)
  );

  for (genvar g = 0; g < int'(NUM_CMP); g++) begin : g_ch
    assign wr_en[g] = cmp_wr_i && (cmp_wsel_i == SEL_W'(g));
    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .count_i(count_o),
      .wr_en_i(wr_en[g]), .wdata_i(cmp_wdata_i),
      .cmp_o(cmp_q[g]), .pend_o(pend[g])
    );
  end

  always_comb begin
    irq_o = '0;
    for (int i = 0; i < int'(NUM_CMP); i++) irq_o[IRQ_POS[i]] = pend[i];
  end

  always_comb begin
    cmp_rdata_o = '0;
    for (int i = 0; i < int'(NUM_CMP); i++)
      if (cmp_rsel_i == SEL_W'(i)) cmp_rdata_o = cmp_q[i];
  end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IRQ_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CNT_W-1:0]              count,
  input logic [NUM_CMP-1:0][CNT_W-1:0] cmp,
  input logic                          wr,
  input logic [SEL_W-1:0]              wsel,
  input logic [IRQ_W-1:0]              irq
);
  localparam logic [IRQ_W-1:0] MASK = IRQ_W'(irq_mask_f());
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |-> (count == '0 && irq == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> count == CNT_W'($past(count) + 1'b1)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(count) == '1) |-> count == '0); // R3
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~MASK) == '0); // R4

  for (genvar g = 0; g < int'(NUM_CMP); g++) begin : g_ch
    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (count == cmp[g] && !(wr && wsel == SEL_W'(g))) |=> irq[IRQ_POS[g]]); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[IRQ_POS[g]] && !(wr && wsel == SEL_W'(g))) |=> irq[IRQ_POS[g]]); // R6
    AST_CLR_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wsel == SEL_W'(g)) |=> !irq[IRQ_POS[g]]); // R7
    AST_NO_FOREIGN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[IRQ_POS[g]] && count != cmp[g]) |=> !irq[IRQ_POS[g]]); // R8
  end
endmodule

bind cyc_cmp_timer cct_timer_chk #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .count(count_o), .cmp(cmp_q),
  .wr(cmp_wr_i), .wsel(cmp_wsel_i), .irq(irq_o)
);

// File: tb/cyc_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cyc_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_wr;
  logic [1:0]  cmp_wsel, cmp_rsel;
  logic [31:0] cmp_wdata, cmp_rdata, count, irq;
  logic [7:0]  w_count, w_rdata;
  logic [31:0] w_irq;

  always #4 clk = ~clk;

  cyc_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_wr_i(cmp_wr), .cmp_wsel_i(cmp_wsel),
    .cmp_wdata_i(cmp_wdata), .cmp_rsel_i(cmp_rsel), .cmp_rdata_o(cmp_rdata),
    .count_o(count), .irq_o(irq)
  );

  cyc_cmp_timer #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .cmp_wr_i(1'b0), .cmp_wsel_i(2'd0),
    .cmp_wdata_i(8'd0), .cmp_rsel_i(2'd0), .cmp_rdata_o(w_rdata),
    .count_o(w_count), .irq_o(w_irq)
  );

  typedef struct { int ch; logic [31:0] at; } exp_t;
  exp_t sbq[$];
  int   checks = 0, fails = 0;
  bit   mon_en = 1'b0;
  logic [2:0] prev = 3'b000;
  int   pos [3] = '{6, 10, 13};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops one expected rise per observed pending-bit rise (R5)
  always @(negedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (mon_en && irq[pos[c]] && !prev[c]) begin
        if (sbq.size() == 0) chk(1'b0, "R5 unexpected rise", 32'(c), 32'hFFFF_FFFF);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(e.ch == c, "R5 rise channel", 32'(c), 32'(e.ch));
          chk(count == e.at, "R5 rise count", count, e.at);
        end
      end
      prev[c] = irq[pos[c]];
    end
  end

  task automatic wr_cmp(input int ch, input logic [31:0] val);
    cmp_wr = 1'b1; cmp_wsel = 2'(ch); cmp_wdata = val;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic arm(input int ch, input logic [31:0] delta, input bit expect_rise);
    logic [31:0] c;
    exp_t e;
    c = count;
    if (expect_rise) begin
      e.ch = ch; e.at = c + delta + 32'd1;
      sbq.push_back(e);
    end
    wr_cmp(ch, c + delta);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 50000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b, c0;
    exp_t e;
    rst_n = 1'b0; cmp_wr = 1'b0; cmp_wsel = 2'd0; cmp_wdata = '0; cmp_rsel = 2'd0;
    wait_n(3);
    chk(count == 0, "R1 count in reset", count, 0);
    chk(irq == 0, "R1 irq in reset", irq, 0);
    for (int s = 0; s < 3; s++) begin
      cmp_rsel = 2'(s); #1;
      chk(cmp_rdata == 0, "R1 compare in reset", cmp_rdata, 0);
    end
    for (int s = 0; s < 3; s++) begin
      e.ch = s; e.at = 32'd1; sbq.push_back(e);
    end
    mon_en = 1'b1;
    rst_n = 1'b1;
    wait_n(6);
    chk(irq == 32'h0000_2440, "R5 all set after reset", irq, 32'h0000_2440);
    chk((irq & ~32'h0000_2440) == 0, "R4 spare bits", irq, 0);

    a = count; @(negedge clk); b = count;
    chk(b == a + 1, "R2 consecutive reads", b - a, 1);

    wr_cmp(0, 32'd0);
    chk(irq == 32'h0000_2400, "R8 write ch0 only clears bit 6", irq, 32'h0000_2400);
    wr_cmp(1, 32'd0);
    wr_cmp(2, 32'd0);
    chk(irq == 0, "R7 all cleared by zero writes", irq, 0);
    wait_n(10);
    chk(irq == 0, "R7 stays clear after zero writes", irq, 0);

    for (int ch = 0; ch < 3; ch++) begin
      c0 = count;
      arm(ch, 32'd20, 1'b1);
      chk(irq[pos[ch]] == 1'b0, "R7 clear right after write", 32'(irq[pos[ch]]), 0);
      cmp_rsel = 2'(ch); #1;
      chk(cmp_rdata == c0 + 20, "R9 read-back", cmp_rdata, c0 + 20);
      wait_n(22);
      chk(irq == (32'h1 << pos[ch]), "R8 only own bit set", irq, 32'h1 << pos[ch]);
      wait_n(30);
      chk(irq[pos[ch]] == 1'b1, "R6 sticky", 32'(irq[pos[ch]]), 1);
      wr_cmp(ch, 32'd0);
    end

    arm(1, 32'd5, 1'b1);
    arm(2, 32'd12, 1'b1);
    wait_n(5);
    chk(irq == 32'h0000_0400, "R8 ch1 set, ch2 pending later", irq, 32'h0000_0400);
    wait_n(8);
    chk(irq == 32'h0000_2400, "R8 both set", irq, 32'h0000_2400);

    arm(0, 32'd1, 1'b1);
    wait_n(2);
    chk(irq[6] == 1'b1, "R5 offset +1", 32'(irq[6]), 1);
    arm(0, 32'd0, 1'b0);
    wait_n(40);
    chk(irq[6] == 1'b0, "R7 passed value never fires", 32'(irq[6]), 0);

    arm(1, 32'd1, 1'b0);
    wr_cmp(1, 32'd0);
    chk(irq[10] == 1'b0, "R7 write beats match", 32'(irq[10]), 0);
    wait_n(3);
    chk(irq[10] == 1'b0, "R7 still clear", 32'(irq[10]), 0);

    cmp_rsel = 2'd3; #1;
    chk(cmp_rdata == 0, "R9 index 3 reads zero", cmp_rdata, 0);

    for (int i = 0; i < 300 && w_count != 8'hFF; i++) @(negedge clk);
    chk(w_count == 8'hFF, "R3 narrow counter at max", 32'(w_count), 32'hFF);
    @(negedge clk);
    chk(w_count == 8'h00, "R3 wrap to zero", 32'(w_count), 0);

    mon_en = 1'b0;
    chk(sbq.size() == 0, "R5 all expected rises seen", 32'(sbq.size()), 0);
    summary();
    $finish;
  end
endmodule